// File: doc/BRIEF.md
# Fused Multiply-Add Align, Add and Normalize Datapath

This block forms the unrounded value of `z + x*y` for finite single-precision operands that an earlier stage has already classified and unpacked. Every significand arrives as 24 bits with the leading one present. Denormals are normalized upstream. Exponents arrive unbiased and signed. Special values (NaN, infinity, a zero product) are resolved before this stage. The block still takes a flag that marks the addend as zero, and in that case it passes the product through.

The significands are multiplied, and the product is placed in a 64-bit working frame with its leading one at bit 62. The addend is placed in the same frame. The operand with the smaller exponent is moved right by the exponent gap. Every bit that falls off during that shift is kept as a sticky bit. The two values are then added or subtracted, and the result is normalized back to bit 62. Only then is the frame narrowed to 24 significand bits plus guard, round and sticky bits.

A following stage rounds and packs the result. The result is registered, so it appears one clock after the operands are presented.

Top module: `fma_align_add`

## Requirements
- R1: The product exponent is `x_exp + y_exp`. When the 48-bit significand product reaches bit 47, one is added to that exponent and the product is moved down one place, so that its leading one always sits at bit 62 of the working frame.
- R2: When `z_zero` is high, the outputs are the product alone: `res_sign = p_sign`, `res_exp` is the product exponent, and `res_zero = 0`.
- R3: The operand with the smaller exponent is shifted right by the exponent difference. Every bit shifted out is ORed into bit 0 of the frame. A difference of 64 or more leaves a frame that holds only that sticky bit. The result exponent is the larger of the two exponents.
- R4: When `z_sign == p_sign`, the aligned values are added. A carry into bit 63 moves the sum right by one place, with sticky, and adds one to the exponent.
- R5: When the signs differ, the smaller aligned value is subtracted from the larger, and `res_sign` is the sign of the larger value.
- R6: A difference of exactly zero gives `res_zero = 1`, `res_sig = 0` and `res_exp = 0`. In that case `res_sign` equals `rnd_down`, which is high only when the rounding mode is toward negative infinity.
- R7: After a subtraction, the result is shifted left in one step until bit 62 is set, and the exponent is lowered by the size of that shift. Every non-zero result therefore has `res_sig[26] = 1`.
- R8: `res_sig` is the 64-bit frame shifted right by 36 with sticky. Bits 26..3 are the significand, bits 2..1 are the guard and round bits, and bit 0 is the sticky bit.
- R9: The outputs are registered with a latency of one clock, and `out_valid` is `in_valid` delayed by one clock. While `rst_n` is low, all outputs are cleared to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operands are valid this cycle |
| rnd_down | input | 1 | Rounding mode is toward negative infinity |
| p_sign | input | 1 | Effective sign of the product |
| x_exp | input | 12 | Unbiased exponent of x, signed |
| x_sig | input | 24 | Significand of x with the leading one set |
| y_exp | input | 12 | Unbiased exponent of y, signed |
| y_sig | input | 24 | Significand of y with the leading one set |
| z_zero | input | 1 | Addend is zero |
| z_sign | input | 1 | Effective sign of the addend |
| z_exp | input | 12 | Unbiased exponent of z, signed |
| z_sig | input | 24 | Significand of z with the leading one set |
| out_valid | output | 1 | Result is valid |
| res_sign | output | 1 | Sign of the result |
| res_exp | output | 12 | Unbiased exponent of the result, signed |
| res_sig | output | 27 | 24-bit significand, then guard, round and sticky bits |
| res_zero | output | 1 | The result is an exact zero |

## Verification
Two functions can act on the same operation: the sticky collapse of a far-distant operand, and the carry renormalization after an add or the cancellation shift after a subtract. When both happen, the sticky bit must survive a second shift. Directed operands provoke this in two ways. One case places a tiny product under a large addend. The other uses the same gap with opposite signs, so that the subtraction borrows through the sticky bit and then normalizes. A random stream with exponent gaps of up to several hundred mixes these cases with carries and exact cancellations. Every case is judged against a bench model that aligns one bit at a time and normalizes with a loop.

// File: rtl/fma_dp_pkg.sv
// Package: sizes shared by the multiply-add align/add/normalize datapath.
// Assumes single-precision significands (24 bits including the leading one).
package fma_dp_pkg;
    parameter int SIG_W   = 24;            // significand width with leading one
    parameter int EXP_W   = 12;            // signed unbiased exponent width
    parameter int FRAME_W = 64;            // working frame width
    parameter int GRS_W   = 3;             // guard, round, sticky bits
    localparam int PROD_W  = 2 * SIG_W;                  // product width
    localparam int OUT_W   = SIG_W + GRS_W;              // narrowed output width
    localparam int LEAD    = FRAME_W - 2;                // position of leading one
    localparam int P_PAD   = FRAME_W - PROD_W;           // product left pad
    localparam int Z_PAD   = LEAD - (SIG_W - 1);         // addend left shift
    localparam int OUT_SHR = LEAD - (OUT_W - 1);         // final narrowing shift
    localparam int CNT_W   = $clog2(FRAME_W + 1);        // leading-zero count width
endpackage

// File: rtl/fma_sticky_shr.sv
// Sticky right shifter: shifts a W-bit value right by amt. Every bit that
// falls off is ORed into bit 0 of the result. Amounts of W or more
// leave only the sticky bit. Purely combinational.
module fma_sticky_shr #(
    parameter int W  = 64,
    parameter int AW = 12
) (
    input  logic [W-1:0]  din,
    input  logic [AW-1:0] amt,
    output logic [W-1:0]  dout
);
    localparam logic [AW-1:0] W_AMT = AW'(W);

    logic [W-1:0] lost_mask;

    // Build the shift result and fold the discarded bits into bit 0.
    always_comb begin
        lost_mask = '0;
        if (amt >= W_AMT) begin
            dout = {{(W-1){1'b0}}, |din};
        end else begin
            lost_mask = ~({W{1'b1}} << amt);
            dout      = (din >> amt) | {{(W-1){1'b0}}, |(din & lost_mask)};
        end
    end
endmodule

// File: rtl/fma_lzc.sv
// Leading-zero counter: returns the number of zero bits above the most
// significant set bit, or W when the input is all zero. Combinational.
module fma_lzc #(
    parameter int W  = 64,
    parameter int CW = 7
) (
    input  logic [W-1:0]  din,
    output logic [CW-1:0] cnt
);
    // Scan upward so that the highest set bit decides the count last.
    always_comb begin
        cnt = CW'(W);
        for (int i = 0; i < W; i++) begin
            if (din[i]) cnt = CW'(W - 1 - i);
        end
    end
endmodule

// File: rtl/fma_align_add.sv
// Multiply-add datapath before rounding: multiplies the significands,
// aligns the product and the addend in a 64-bit frame with sticky shifts,
// adds or subtracts them, normalizes to bit 62, and narrows the frame to
// 24+3 bits. Assumes finite, non-special operands with normalized
// significands. One register stage, synchronous active-low reset.
module fma_align_add
    import fma_dp_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic                    rnd_down,
    input  logic                    p_sign,
    input  logic signed [EXP_W-1:0] x_exp,
    input  logic [SIG_W-1:0]        x_sig,
    input  logic signed [EXP_W-1:0] y_exp,
    input  logic [SIG_W-1:0]        y_sig,
    input  logic                    z_zero,
    input  logic                    z_sign,
    input  logic signed [EXP_W-1:0] z_exp,
    input  logic [SIG_W-1:0]        z_sig,
    output logic                    out_valid,
    output logic                    res_sign,
    output logic signed [EXP_W-1:0] res_exp,
    output logic [OUT_W-1:0]        res_sig,
    output logic                    res_zero
);
    logic [PROD_W-1:0]         prod_raw;
    logic [FRAME_W-1:0]        p_wide, p_frame, z_frame;
    logic                      p_over;
    logic signed [EXP_W-1:0]   p_exp, e_diff, al_exp;
    logic                      z_bigger;
    logic [EXP_W-1:0]          p_amt, z_amt;
    logic [FRAME_W-1:0]        p_al, z_al;
    logic                      same_sgn, z_ge;
    logic [FRAME_W-1:0]        sum, sum_n, dif, dif_n;
    logic [CNT_W-1:0]          lz, nshift;
    logic [FRAME_W-1:0]        pre_frame, fin_frame;
    logic signed [EXP_W-1:0]   pre_exp;
    logic                      pre_sign, exact_zero;

    // Form the product and place its leading one at bit 62.
    always_comb begin
        prod_raw = PROD_W'(x_sig) * PROD_W'(y_sig);
        p_wide   = {prod_raw, {P_PAD{1'b0}}};
        p_over   = p_wide[FRAME_W-1];
        p_frame  = p_over ? (p_wide >> 1) : p_wide;
        p_exp    = x_exp + y_exp + EXP_W'(p_over);
        z_frame  = {1'b0, z_sig, {Z_PAD{1'b0}}};
    end

    // Pick which operand moves and by how much.
    always_comb begin
        e_diff   = z_exp - p_exp;
        z_bigger = e_diff > 0;
        p_amt    = z_bigger ? e_diff : '0;
        z_amt    = z_bigger ? '0 : -e_diff;
        al_exp   = z_bigger ? z_exp : p_exp;
    end

    fma_sticky_shr #(.W(FRAME_W), .AW(EXP_W)) u_shr_p (.din(p_frame), .amt(p_amt), .dout(p_al));
    fma_sticky_shr #(.W(FRAME_W), .AW(EXP_W)) u_shr_z (.din(z_frame), .amt(z_amt), .dout(z_al));

    // Add for equal signs, subtract smaller from larger otherwise.
    always_comb begin
        same_sgn = (z_sign == p_sign);
        sum      = z_al + p_al;
        sum_n    = sum[FRAME_W-1] ? ({1'b0, sum[FRAME_W-1:1]} | {{(FRAME_W-1){1'b0}}, sum[0]}) : sum;
        z_ge     = (z_al >= p_al);
        dif      = z_ge ? (z_al - p_al) : (p_al - z_al);
    end

    fma_lzc #(.W(FRAME_W), .CW(CNT_W)) u_lzc (.din(dif), .cnt(lz));

    // Normalize the difference with one barrel shift and choose the path.
    always_comb begin
        nshift     = lz - CNT_W'(1);
        dif_n      = dif << nshift;
        exact_zero = 1'b0;
        if (z_zero) begin
            pre_frame = p_frame;
            pre_exp   = p_exp;
            pre_sign  = p_sign;
        end else if (same_sgn) begin
            pre_frame = sum_n;
            pre_exp   = al_exp + EXP_W'(sum[FRAME_W-1]);
            pre_sign  = z_sign;
        end else begin
            pre_frame  = dif_n;
            pre_exp    = al_exp - EXP_W'(nshift);
            pre_sign   = z_ge ? z_sign : p_sign;
            exact_zero = (dif == '0);
        end
    end

    fma_sticky_shr #(.W(FRAME_W), .AW(EXP_W)) u_shr_out (
        .din(pre_frame), .amt(EXP_W'(OUT_SHR)), .dout(fin_frame));

    // Register the result stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            res_sign  <= 1'b0;
            res_exp   <= '0;
            res_sig   <= '0;
            res_zero  <= 1'b0;
        end else begin
            out_valid <= in_valid;
            res_zero  <= exact_zero;
            if (exact_zero) begin
                res_sign <= rnd_down;
                res_exp  <= '0;
                res_sig  <= '0;
            end else begin
                res_sign <= pre_sign;
                res_exp  <= pre_exp;
                res_sig  <= fin_frame[OUT_W-1:0];
            end
        end
    end

    // R9
    valid_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> out_valid == $past(in_valid && rst_n));
    // R7
    lead_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !res_zero) |-> res_sig[OUT_W-1]);
    // R6
    zero_sig_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && res_zero) |-> (res_sig == '0 && res_exp == '0));
    // R6
    zero_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && res_zero) |-> res_sign == $past(rnd_down));
    // R2
    pass_prod_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && z_zero) |=> (!res_zero && res_sign == $past(p_sign)));
endmodule

// File: tb/fma_align_add_test.sv
module fma_align_add_test;
    localparam int CLK_PERIOD = 10;
    localparam int N_RAND     = 3000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0, rnd_down = 1'b0, p_sign = 1'b0, z_zero = 1'b0, z_sign = 1'b0;
    logic signed [11:0] x_exp = '0, y_exp = '0, z_exp = '0;
    logic [23:0] x_sig = '0, y_sig = '0, z_sig = '0;
    logic out_valid, res_sign, res_zero;
    logic signed [11:0] res_exp;
    logic [26:0] res_sig;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fma_align_add uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .rnd_down(rnd_down),
        .p_sign(p_sign), .x_exp(x_exp), .x_sig(x_sig), .y_exp(y_exp), .y_sig(y_sig),
        .z_zero(z_zero), .z_sign(z_sign), .z_exp(z_exp), .z_sig(z_sig),
        .out_valid(out_valid), .res_sign(res_sign), .res_exp(res_exp),
        .res_sig(res_sig), .res_zero(res_zero));

    // One-bit-at-a-time sticky right shift.
    function automatic logic [63:0] m_shr(logic [63:0] v, int n);
        for (int i = 0; i < n && i < 70; i++) v = (v >> 1) | (v & 64'd1);
        return v;
    endfunction

    // Reference model built from the requirements.
    function automatic void model(output logic s, output int e, output logic [26:0] m, output logic zr);
        logic [63:0] pf, zf, acc;
        int pe, ze, ea;
        pf = {16'(0), 48'(x_sig) * 48'(y_sig)} << 16;
        pe = int'(x_exp) + int'(y_exp);
        if (pf[63]) begin pf = pf >> 1; pe++; end
        zr = 1'b0;
        if (z_zero) begin
            s = p_sign; e = pe; m = m_shr(pf, 36); return;
        end
        zf = 64'(z_sig) << 39;
        ze = int'(z_exp);
        if (ze > pe) begin pf = m_shr(pf, ze - pe); ea = ze; end
        else begin zf = m_shr(zf, pe - ze); ea = pe; end
        if (z_sign == p_sign) begin
            acc = zf + pf; s = z_sign;
            if (acc[63]) begin acc = m_shr(acc, 1); ea++; end
        end else begin
            if (zf >= pf) begin acc = zf - pf; s = z_sign; end
            else begin acc = pf - zf; s = p_sign; end
            if (acc == 0) begin zr = 1'b1; s = rnd_down; e = 0; m = '0; return; end
            while (!acc[62]) begin acc = acc << 1; ea--; end
        end
        e = ea; m = m_shr(acc, 36);
    endfunction

    task automatic check(input string tag, input logic es, input int ee, input logic [26:0] em, input logic ez);
        n_chk++;
        if (!(out_valid && res_sign === es && int'(res_exp) == ee && res_sig === em && res_zero === ez)) begin
            n_bad++;
            $display("FAIL %s: got v=%0b s=%0b e=%0d m=%h z=%0b, want s=%0b e=%0d m=%h z=%0b",
                     tag, out_valid, res_sign, res_exp, res_sig, res_zero, es, ee, em, ez);
        end
    endtask

    // Drive one operation, wait one clock, compare with model and, if given, a literal.
    task automatic op(input string tag, input logic ps, input int xe, input logic [23:0] xm,
                      input int ye, input logic [23:0] ym, input logic zz, input logic zs,
                      input int ze, input logic [23:0] zm, input logic rd);
        logic s, zr; int e; logic [26:0] m;
        @(negedge clk);
        in_valid = 1'b1; p_sign = ps; x_exp = 12'(xe); x_sig = xm; y_exp = 12'(ye); y_sig = ym;
        z_zero = zz; z_sign = zs; z_exp = 12'(ze); z_sig = zm; rnd_down = rd;
        model(s, e, m, zr);
        @(negedge clk);
        check(tag, s, e, m, zr);
    endtask

    task automatic lit(input string tag, input logic es, input int ee, input logic [26:0] em, input logic ez);
        check(tag, es, ee, em, ez);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got hang, want completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R9 reset state
        n_chk++;
        if (out_valid !== 1'b0 || res_sign !== 1'b0 || res_exp !== '0 || res_sig !== '0 || res_zero !== 1'b0) begin
            n_bad++;
            $display("FAIL R9 reset: got v=%0b s=%0b e=%0d m=%h z=%0b, want all zero",
                     out_valid, res_sign, res_exp, res_sig, res_zero);
        end
        rst_n = 1'b1;

        // R4 1*1+1 = 2: carry shifts down, exponent 1
        op("R4 carry", 0, 0, 24'h800000, 0, 24'h800000, 0, 0, 0, 24'h800000, 0);
        lit("R4 literal", 0, 1, 27'h4000000, 0);
        // R1 R2 1.5*1.5 with zero addend
        op("R1 R2 product", 1, 0, 24'hC00000, 0, 24'hC00000, 1, 0, 0, 24'h0, 0);
        lit("R1 literal", 1, 1, 27'h4800000, 0);
        // R6 exact cancellation, both rounding modes
        op("R6 zero rd", 1, 0, 24'h800000, 0, 24'h800000, 0, 0, 0, 24'h800000, 1);
        lit("R6 literal neg", 1, 0, 27'h0, 1);
        op("R6 zero rn", 0, 3, 24'hA5A5A5, 0, 24'h800000, 0, 1, 3, 24'hA5A5A5, 0);
        lit("R6 literal pos", 0, 0, 27'h0, 1);
        // R3 R8 far product collapses into sticky
        op("R3 sticky", 0, -60, 24'h800000, -60, 24'h800000, 0, 0, 0, 24'h800000, 0);
        lit("R8 literal", 0, 0, 27'h4000001, 0);
        // R5 R7 subtraction with renormalization, addend larger
        op("R7 norm", 1, -1, 24'hC00000, 0, 24'h800000, 0, 0, 0, 24'h800000, 0);
        lit("R7 literal", 0, -2, 27'h4000000, 0);
        // R5 product larger: result takes product sign
        op("R5 sign", 1, 1, 24'hC00000, 0, 24'h800000, 0, 0, 0, 24'h800000, 0);
        lit("R5 literal", 1, 1, 27'h4000000, 0);
        // R3 R7 far sticky with borrow: addend large, tiny opposite product
        op("R3 borrow", 1, -100, 24'h800000, -100, 24'h800000, 0, 0, 0, 24'h800000, 0);
        lit("R3 literal", 0, -1, 27'h7FFFFFF, 0);
        // R3 addend far below product
        op("R3 z tiny", 0, 50, 24'hFFFFFF, 50, 24'hFFFFFF, 0, 1, -120, 24'h812345, 0);

        // Random stream: R1 R2 R3 R4 R5 R6 R7 R8
        for (int k = 0; k < N_RAND; k++) begin
            logic [23:0] a, b, c; int ea, eb, ec; logic zz, sa, sc, rd;
            a  = 24'($urandom) | 24'h800000;
            b  = 24'($urandom) | 24'h800000;
            c  = 24'($urandom) | 24'h800000;
            ea = int'($urandom_range(0, 276)) - 149;
            eb = int'($urandom_range(0, 276)) - 149;
            ec = ((k % 3) == 0) ? (ea + eb + int'($urandom_range(0, 8)) - 4)
                                : (int'($urandom_range(0, 276)) - 149);
            zz = ($urandom_range(0, 7) == 0);
            sa = 1'($urandom); sc = 1'($urandom); rd = 1'($urandom);
            if ((k % 8) == 5) begin
                b = 24'h800000; eb = 0; c = a; ec = ea; sc = ~sa; zz = 1'b0;
            end
            op("R8 random", sa, ea, a, eb, b, zz, sc, ec, c, rd);
        end

        // R9 valid drops one clock after in_valid drops
        @(negedge clk); in_valid = 1'b0;
        @(negedge clk);
        n_chk++;
        if (out_valid !== 1'b0) begin
            n_bad++;
            $display("FAIL R9 valid: got %0b, want 0", out_valid);
        end

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule